// File: doc/BRIEF.md
# Glitch-Free Clock Gate with Restart Sequencer

This block passes an input clock to a bank of programmable clock dividers. An active-high enable starts and stops the gated clock. The level the gated clock rests at while stopped is a build-time choice, either low or high. The enable can act in one of two modes. In synchronous mode it is sampled against the input clock, so that no shortened pulse can appear. In asynchronous mode it forces the output at once, which suits a clock that is already stopped or a non-clock signal.

When the dividers run at ratios above one, their counters have to be brought back into step after the gate has been stopped. A small sequencer handles this. It runs on a free-running control clock and, on a restart request, performs these steps in order:

1. Stop the gate.
2. Wait until the input clock has run through the drain window.
3. Pulse the divider clear.
4. Re-open the gate.

As a result, every divided output rises on the same gated edge. When every ratio is one, the clear step is skipped.

Top module: `clk_gate_restart`

## Requirements
- R1: While the effective enable is high, `gclk_o` follows `clk_i`.
- R2: While the effective enable is low, `gclk_o` holds `STOP_LEVEL` (default 0). The effective enable is `en_i` AND the sequencer's gate enable.
- R3: During and after reset, `gclk_o` sits at `STOP_LEVEL` until the enable has been taken in. Also during reset, `div_clr_o` and `done_o` are 0 and every divided output with ratio above one is 0.
- R4: In synchronous mode, an enable change never shortens a phase. With stop-low, a drop in the high phase lets that high phase finish. With stop-high, a rise in the high phase leaves the output at 1 until the next rising input edge.
- R5: In asynchronous mode, the enable acts on `gclk_o` immediately, in the middle of a clock phase.
- R6: A restart produces these events in order: the gate stops, `div_clr_o` rises, `div_clr_o` falls, then the gate reopens. No gated edge occurs while the clear is high.
- R7: `div_clr_o` stays high for exactly `CLR_CYCLES` (default 2) control cycles. It rises no earlier than `WAIT_PERIODS` (default 2) input-clock periods after the request.
- R8: When every ratio field is 0 (divide by 1), a restart reopens the gate without raising `div_clr_o`.
- R9: `done_o` is a single control-cycle pulse, given in the cycle the gate enable returns high.
- R10: Restart requests that arrive while a sequence is running are ignored: one request gives exactly one clear pulse and one done pulse.
- R11: Field k of `ratio_i` is bits [3k+2:3k]. A value v divides by N = v+1, and the output is high for floor(N/2) of every N gated cycles. With v = 0 the output is the gated clock itself.
- R12: The clear forces divided outputs to 0. After a restart, every divided output rises on the first gated rising edge and then follows its own ratio from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be gated |
| ctl_clk_i | input | 1 | Free-running control clock for the sequencer |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Active-high gate enable |
| restart_i | input | 1 | Restart request, synchronous to ctl_clk_i |
| ratio_i | input | NUM_DIV*3 | Per-divider ratio fields, value v divides by v+1 |
| gclk_o | output | 1 | Gated clock |
| div_clk_o | output | NUM_DIV | Divided clocks |
| div_clr_o | output | 1 | Divider clear from the sequencer |
| done_o | output | 1 | One-cycle pulse when a restart completes |

## Verification
The bench drops and raises the enable in the middle of each clock phase, for all three gate variants side by side. A gate that sampled on the wrong edge would clip a high pulse or let a short spike through. An asynchronous gate that waited for an edge would leave the output running for part of a phase.

Restarts are issued with a second request arriving while the first sequence is still running. A sequencer that re-armed would produce two clear pulses, and one that cut the drain short would raise the clear while gated edges were still arriving.

After the clear, the divided outputs are compared edge by edge against patterns built from the ratio fields. A divider left misaligned, or one with a wrong duty count, shows up on the first gated edge. The all-bypass restart catches a sequencer that clears when it need not.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  typedef enum logic {GATE_SYNC = 1'b0, GATE_ASYNC = 1'b1} gate_mode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_DRAIN, SQ_CLEAR, SQ_GAP} seq_state_e;
  localparam int unsigned RATIO_W = 3;
endpackage

// File: rtl/cgr_gate.sv
module cgr_gate
  import cgr_pkg::*;
#(
  parameter gate_mode_e MODE       = GATE_SYNC,
  parameter bit         STOP_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  if (MODE == GATE_ASYNC) begin : g_async
    assign gclk_o = (en_i && rst_ni) ? clk_i : STOP_LEVEL;
  end else if (STOP_LEVEL == 1'b0) begin : g_sync_low
    logic en_q;
    // capture while clk is low so the AND cannot clip a high phase
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= en_i;
    end
    assign gclk_o = clk_i & en_q;
  end else begin : g_sync_high
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= en_i;
    end
    assign gclk_o = clk_i | ~en_q;
  end
endmodule

// File: rtl/cgr_div.sv
module cgr_div
  import cgr_pkg::*;
(
  input  logic               gclk_i,
  input  logic               clr_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_o
);
  logic [RATIO_W-1:0] cnt_q, cnt_nxt;
  logic [RATIO_W:0]   hi_len;
  logic               q;

  assign cnt_nxt = (cnt_q >= ratio_i) ? '0 : cnt_q + 1'b1;
  assign hi_len  = ({1'b0, ratio_i} + 1'b1) >> 1;

  // clear parks the counter at its top so the first edge wraps to phase 0
  always_ff @(posedge gclk_i or posedge clr_i) begin
    if (clr_i) begin
      cnt_q <= '1;
      q     <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      q     <= ({1'b0, cnt_nxt} < hi_len);
    end
  end

  assign div_o = (ratio_i == '0) ? gclk_i : q;
endmodule

// File: rtl/cgr_seq.sv
module cgr_seq
  import cgr_pkg::*;
#(
  parameter int unsigned WAIT_PERIODS = 2,
  parameter int unsigned CLR_CYCLES   = 2
) (
  input  logic ctl_clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic restart_i,
  input  logic bypass_i,
  output logic gate_en_o,
  output logic clr_o,
  output logic done_o
);
  localparam int unsigned CNT_MAX = (WAIT_PERIODS > CLR_CYCLES) ? WAIT_PERIODS : CLR_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_PERIODS);
  localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(CLR_CYCLES - 1);

  logic       tgl_q;
  logic [2:0] sync_q;
  logic       tick;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  always_ff @(posedge ctl_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tgl_q};
  end

  // one tick per input period; WAIT_PERIODS+1 ticks cover whole periods
  assign tick = sync_q[2] ^ sync_q[1];

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge ctl_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      gate_en_o <= 1'b1;
      clr_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (restart_i) begin
            state_q   <= SQ_DRAIN;
            gate_en_o <= 1'b0;
            cnt_q     <= '0;
          end
        end
        SQ_DRAIN: begin
          if (tick) begin
            if (cnt_q == WAIT_LAST) begin
              cnt_q <= '0;
              if (bypass_i) begin
                state_q   <= SQ_IDLE;
                gate_en_o <= 1'b1;
                done_o    <= 1'b1;
              end else begin
                state_q <= SQ_CLEAR;
                clr_o   <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        SQ_CLEAR: begin
          if (cnt_q == CLR_LAST) begin
            clr_o   <= 1'b0;
            state_q <= SQ_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_GAP: begin
          state_q   <= SQ_IDLE;
          gate_en_o <= 1'b1;
          done_o    <= 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_gate_restart.sv
module clk_gate_restart
  import cgr_pkg::*;
#(
  parameter gate_mode_e  GATE_MODE    = GATE_SYNC,
  parameter bit          STOP_LEVEL   = 1'b0,
  parameter int unsigned NUM_DIV      = 3,
  parameter int unsigned WAIT_PERIODS = 2,
  parameter int unsigned CLR_CYCLES   = 2
) (
  input  logic                       clk_i,
  input  logic                       ctl_clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       restart_i,
  input  logic [NUM_DIV*RATIO_W-1:0] ratio_i,
  output logic                       gclk_o,
  output logic [NUM_DIV-1:0]         div_clk_o,
  output logic                       div_clr_o,
  output logic                       done_o
);
  logic seq_en;
  logic gate_en;
  logic div_rst;
  logic bypass;

  assign bypass = (ratio_i == '0);

  cgr_seq #(
    .WAIT_PERIODS(WAIT_PERIODS),
    .CLR_CYCLES  (CLR_CYCLES)
  ) u_seq (
    .ctl_clk_i(ctl_clk_i),
    .rst_ni   (rst_ni),
    .ref_clk_i(clk_i),
    .restart_i(restart_i),
    .bypass_i (bypass),
    .gate_en_o(seq_en),
    .clr_o    (div_clr_o),
    .done_o   (done_o)
  );

  assign gate_en = en_i & seq_en;

  cgr_gate #(
    .MODE      (GATE_MODE),
    .STOP_LEVEL(STOP_LEVEL)
  ) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (gate_en),
    .gclk_o(gclk_o)
  );

  assign div_rst = div_clr_o | ~rst_ni;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    cgr_div u_div (
      .gclk_i (gclk_o),
      .clr_i  (div_rst),
      .ratio_i(ratio_i[g*RATIO_W +: RATIO_W]),
      .div_o  (div_clk_o[g])
    );
  end
endmodule

// File: rtl/cgr_chk.sv
module cgr_chk #(
  parameter bit STOP_LEVEL = 1'b0
) (
  input logic ctl_clk_i,
  input logic clk_i,
  input logic rst_ni,
  input logic gate_en_i,
  input logic seq_en_i,
  input logic clr_i,
  input logic done_i,
  input logic gclk_i
);
  AST_CLR_MIN_HOLD: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    $rose(clr_i) |=> clr_i);  // R7
  AST_CLR_GATE_SHUT: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    clr_i |-> !gate_en_i);  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);  // R9
  AST_DONE_WITH_ENABLE: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    done_i |-> (seq_en_i && !clr_i));  // R9
  AST_STOPPED_LEVEL: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!gate_en_i && !$past(gate_en_i)) |-> (gclk_i == STOP_LEVEL));  // R2
endmodule

bind clk_gate_restart cgr_chk #(.STOP_LEVEL(STOP_LEVEL)) chk_i (
  .ctl_clk_i(ctl_clk_i),
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gate_en_i(gate_en),
  .seq_en_i (seq_en),
  .clr_i    (div_clr_o),
  .done_i   (done_o),
  .gclk_i   (gclk_o)
);

// File: tb/clk_gate_restart_tb_top.sv
module clk_gate_restart_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int      CLK_PERIOD = 10;
  localparam realtime CTL_HALF   = 3.3;
  localparam int      NDIV       = 3;
  localparam int      CLR_CYC    = 2;
  localparam int      WAIT_PER   = 2;

  typedef enum int {EV_CLR_RISE, EV_CLR_FALL, EV_DONE} ev_e;

  logic clk = 1'b0, ctl_clk = 1'b0, rst_n, en, restart;
  logic [NDIV*3-1:0] ratio;
  logic gclk, clr, done;
  logic [NDIV-1:0] div;
  logic gclk_hi, div_hi, clr_hi, done_hi;
  logic gclk_as, clr_as, done_as;
  logic [NDIV-1:0] div_as;

  ev_e          ev_q[$];
  logic [NDIV-1:0] div_q[$];
  realtime t_req = 0;
  int gcnt = 0;
  int m_chk = 0, m_err = 0, e_chk = 0, e_err = 0, d_chk = 0, d_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always #(CTL_HALF) ctl_clk = ~ctl_clk;

  clk_gate_restart #(.NUM_DIV(NDIV), .WAIT_PERIODS(WAIT_PER), .CLR_CYCLES(CLR_CYC)) dut_i (
    .clk_i(clk), .ctl_clk_i(ctl_clk), .rst_ni(rst_n), .en_i(en), .restart_i(restart),
    .ratio_i(ratio), .gclk_o(gclk), .div_clk_o(div), .div_clr_o(clr), .done_o(done));

  clk_gate_restart #(.STOP_LEVEL(1'b1), .NUM_DIV(1)) dut_hi_i (
    .clk_i(clk), .ctl_clk_i(ctl_clk), .rst_ni(rst_n), .en_i(en), .restart_i(1'b0),
    .ratio_i(3'd0), .gclk_o(gclk_hi), .div_clk_o(div_hi), .div_clr_o(clr_hi), .done_o(done_hi));

  clk_gate_restart #(.GATE_MODE(cgr_pkg::GATE_ASYNC), .NUM_DIV(NDIV)) dut_as_i (
    .clk_i(clk), .ctl_clk_i(ctl_clk), .rst_ni(rst_n), .en_i(en), .restart_i(1'b0),
    .ratio_i(ratio), .gclk_o(gclk_as), .div_clk_o(div_as), .div_clr_o(clr_as), .done_o(done_as));

  function automatic int fails(string req, int act, int exp);
    if (act != exp) begin
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $realtime);
      return 1;
    end
    return 0;
  endfunction

  function automatic logic [NDIV-1:0] div_pattern(int e, logic [NDIV*3-1:0] r);
    logic [NDIV-1:0] v;
    for (int k = 0; k < NDIV; k++) begin
      int n = int'(r[k*3 +: 3]) + 1;
      v[k] = ((e % n) < (n / 2)) || (n == 1);
    end
    return v;
  endfunction

  always @(posedge gclk) gcnt++;

  // monitor: divided outputs checked one gated edge at a time
  always @(posedge gclk) begin
    logic [NDIV-1:0] exp_v;
    #1;
    if (div_q.size() != 0) begin
      exp_v = div_q.pop_front();
      d_chk++;
      d_err += fails("R12 R11 divided output pattern", int'(div), int'(exp_v));
    end
  end

  // monitor: sequencer events against the expected queue
  logic clr_prev = 1'b0, done_prev = 1'b0;
  int clr_len = 0, g_at_rise = 0;
  always @(negedge ctl_clk) begin
    if (rst_n === 1'b1) begin
      if (clr && !clr_prev) begin
        e_chk++;
        if (ev_q.size() == 0) e_err += fails("R10 R8 unexpected clear rise", 1, 0);
        else e_err += fails("R6 event order at clear rise", int'(ev_q.pop_front()), int'(EV_CLR_RISE));
        e_chk++;
        e_err += fails("R7 drain wait before clear", int'($realtime - t_req >= 2 * CLK_PERIOD), 1);
        e_chk++;
        e_err += fails("R12 clear forces divided outputs low", int'(div), 0);
        clr_len = 0;
        g_at_rise = gcnt;
      end
      if (clr) clr_len++;
      if (!clr && clr_prev) begin
        e_chk++;
        if (ev_q.size() == 0) e_err += fails("R10 unexpected clear fall", 1, 0);
        else e_err += fails("R6 event order at clear fall", int'(ev_q.pop_front()), int'(EV_CLR_FALL));
        e_chk++;
        e_err += fails("R7 clear length", clr_len, CLR_CYC);
        e_chk++;
        e_err += fails("R6 gated edges during clear", gcnt - g_at_rise, 0);
      end
      if (done && !done_prev) begin
        e_chk++;
        if (ev_q.size() == 0) e_err += fails("R10 unexpected done", 1, 0);
        else e_err += fails("R6 event order at done", int'(ev_q.pop_front()), int'(EV_DONE));
      end
      if (done && done_prev) begin
        e_chk++;
        e_err += fails("R9 done wider than one cycle", 1, 0);
      end
      clr_prev  = clr;
      done_prev = done;
    end
  end

  task automatic chk(string req, int act, int exp);
    m_chk++;
    m_err += fails(req, act, exp);
  endtask

  task automatic pulse_restart();
    @(negedge ctl_clk);
    restart = 1'b1;
    @(negedge ctl_clk);
    restart = 1'b0;
  endtask

  task automatic wait_done();
    bit seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge ctl_clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    chk("R9 done pulse reached", int'(seen), 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors",
             m_chk + e_chk + d_chk, m_err + e_err + d_err);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    m_chk++;
    m_err++;
    $display("FAIL R9 watchdog expired: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; restart = 1'b0;
    ratio = {3'd3, 3'd2, 3'd1};
    repeat (3) @(posedge clk);
    #2;
    chk("R3 reset gclk stop-low", int'(gclk), 0);
    chk("R3 reset gclk async", int'(gclk_as), 0);
    chk("R3 reset divided outputs", int'(div), 0);
    chk("R3 reset clear", int'(clr), 0);
    chk("R3 reset done", int'(done), 0);
    @(negedge clk); #2;
    chk("R3 reset gclk stop-high", int'(gclk_hi), 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #2;
    chk("R2 enable low stop-low", int'(gclk), 0);
    @(negedge clk); #2;
    chk("R2 enable low stop-high", int'(gclk_hi), 1);

    @(negedge clk); #1 en = 1'b1;
    repeat (3) @(posedge clk); #2;
    chk("R1 high phase sync-low", int'(gclk), 1);
    chk("R1 high phase sync-high", int'(gclk_hi), 1);
    chk("R1 high phase async", int'(gclk_as), 1);
    @(negedge clk); #2;
    chk("R1 low phase sync-low", int'(gclk), 0);
    chk("R1 low phase sync-high", int'(gclk_hi), 0);
    chk("R1 low phase async", int'(gclk_as), 0);

    @(posedge clk); #2 en = 1'b0;
    #1;
    chk("R4 high phase not clipped", int'(gclk), 1);
    chk("R5 async stops mid phase", int'(gclk_as), 0);
    @(negedge clk); #2;
    chk("R4 stop-high low phase kept", int'(gclk_hi), 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      chk("R2 held low sync", int'(gclk), 0);
      chk("R2 held low async", int'(gclk_as), 0);
      @(negedge clk); #2;
      chk("R2 held high stop-high", int'(gclk_hi), 1);
    end

    @(posedge clk); #2 en = 1'b1;
    #1;
    chk("R5 async starts mid phase", int'(gclk_as), 1);
    chk("R4 no runt on start", int'(gclk), 0);
    @(negedge clk); #2;
    chk("R4 stop-high waits for rising edge", int'(gclk_hi), 1);
    repeat (2) @(posedge clk); #2;
    chk("R1 running again", int'(gclk & gclk_hi & gclk_as), 1);

    // disturb divider phases, then restart with dividers in use
    ratio = {3'd1, 3'd1, 3'd1};
    repeat (5) @(posedge clk);
    ratio = {3'd3, 3'd2, 3'd1};
    repeat (3) @(posedge clk);
    ev_q.push_back(EV_CLR_RISE);
    ev_q.push_back(EV_CLR_FALL);
    ev_q.push_back(EV_DONE);
    @(negedge ctl_clk);
    restart = 1'b1;
    t_req = $realtime;
    @(negedge ctl_clk);
    restart = 1'b0;
    repeat (3) @(negedge ctl_clk);
    pulse_restart();  // R10 request while busy
    wait_done();
    for (int e = 0; e < 12; e++) div_q.push_back(div_pattern(e, ratio));
    #1;
    chk("R12 outputs low before first gated edge", int'(div), 0);
    repeat (30) @(posedge clk);
    chk("R12 all pattern edges seen", div_q.size(), 0);
    repeat (20) @(negedge ctl_clk);
    chk("R10 single sequence per request", ev_q.size(), 0);

    // bypass restart
    ratio = '0;
    repeat (4) @(posedge clk);
    ev_q.push_back(EV_DONE);
    @(negedge ctl_clk);
    restart = 1'b1;
    t_req = $realtime;
    @(negedge ctl_clk);
    restart = 1'b0;
    wait_done();
    @(posedge gclk); #1;
    chk("R11 bypass follows gated clock high", int'(div), 7);
    @(negedge gclk); #1;
    chk("R11 bypass follows gated clock low", int'(div), 0);
    repeat (20) @(negedge ctl_clk);
    chk("R8 bypass restart without clear", ev_q.size(), 0);

    summary();
    $finish;
  end
endmodule